// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block sits on the host side of an 8-bit NAND flash bus where commands, addresses and data share the same lines. A request supplies an operation code, a column byte, a 24-bit row address and a byte count. The block then produces the required series of command, address and data bus cycles. Each cycle is a write strobe or a read strobe whose low and high widths are set in system clocks.

After the confirm command of a long operation, the block watches the ready/busy line. A watchdog counter abandons the wait if the line stays low too long. For program and erase, the block then reads the status byte and reports it. Write data for page program arrives one byte at a time over a ready/valid stream. Bytes read from the page or from the identification area leave on a strobe-qualified output. Each request ends with a single response pulse that carries the status byte, a pass/fail bit and a timeout bit.

Top module: `nand_seq`

## Requirements
- R1: After reset the chip enable, write strobe and read strobe are high, write protect is low, `req_ready` is high and `resp_valid` is low.
- R2: A command cycle has `nf_cle` high and an address cycle has `nf_ale` high, never both. The flash captures the byte on the rising edge of `nf_we_n`. The data byte stays stable while `nf_we_n` is low, and `nf_cle`, `nf_ale` and the data byte are unchanged across that rising edge.
- R3: Every write strobe stays low for `cfg_wlo` clocks. Every read strobe stays low for `cfg_rlo` clocks, and input data is taken on the last of those clocks. High phases last at least `cfg_whi` and `cfg_rhi` clocks. A setting of zero acts as one. The two strobes are never low together.
- R4: Operation code 0 (page read) sends command 00h, then the column byte, then row bits 7:0, 15:8 and 23:16. It waits for ready, then reads `req_len` bytes and presents each on `rd_data` with a one-clock `rd_valid`. When `req_len` is 0, no bytes are read.
- R5: Operation code 1 (page program) sends 80h and the same four address bytes. It then sends `req_len` data bytes taken in order from the write stream, then 10h. It waits for ready, then sends 70h and reads one status byte.
- R6: Operation code 2 (block erase) sends 60h, the three row bytes only and D0h. It waits for ready, then sends 70h and reads one status byte.
- R7: Operation code 3 sends 70h and reads one status byte. Operation code 4 sends 90h, one address byte of 00h, and reads `req_len` bytes to `rd_data`. Operation code 5 sends FFh and waits for ready.
- R8: For codes 1, 2 and 3, `resp_status` carries the status byte read and `resp_fail` equals its bit 0. For all other codes both are zero.
- R9: The block ignores `nf_rb` for a guard period after it enters the busy wait, and it resynchronises the line through two flops. If the line is still low when the wait has lasted `cfg_busy_lim` clocks, the response has `resp_timeout` high and no further bus cycles are issued.
- R10: `nf_wp_n` is high only while a program or erase request is in progress, and low otherwise.
- R11: `resp_valid` is a single-clock pulse, after which `req_ready` is high and chip enable is high. Operation codes 6 and 7 produce a response without any bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this clock |
| req_op | input | 3 | Operation code |
| req_col | input | 8 | Column address byte |
| req_row | input | 24 | Row address |
| req_len | input | LEN_W | Data bytes to transfer |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte present |
| wr_ready | output | 1 | Block takes the program byte |
| rd_data | output | 8 | Byte read from the flash |
| rd_valid | output | 1 | `rd_data` is valid this clock |
| resp_valid | output | 1 | Request complete |
| resp_status | output | 8 | Status byte read |
| resp_fail | output | 1 | Bit 0 of the status byte |
| resp_timeout | output | 1 | Busy wait exceeded its limit |
| cfg_wlo | input | TW | Write strobe low clocks |
| cfg_whi | input | TW | Write strobe high clocks |
| cfg_rlo | input | TW | Read strobe low clocks |
| cfg_rhi | input | TW | Read strobe high clocks |
| cfg_busy_lim | input | BW | Busy wait limit in clocks |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command cycle marker |
| nf_ale | output | 1 | Address cycle marker |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_wp_n | output | 1 | Write protect, active low |
| nf_dq_o | output | 8 | Byte driven to the flash |
| nf_dq_oe | output | 1 | Output enable for `nf_dq_o` |
| nf_dq_i | input | 8 | Byte from the flash |
| nf_rb | input | 1 | Ready (high) / busy (low) |

## Verification
The assertions watch the bus protocol on every clock:
- command and address markers are exclusive;
- the data byte stays stable through a write strobe;
- markers and data hold across the rising edge;
- the minimum write strobe low time is met;
- the strobes never overlap;
- chip enable gates both strobes;
- write protect is released only inside a request;
- the response is a single pulse.

Some behaviour only the bench scenarios can show. These are the exact cycle order and byte values of each operation, the program bytes taken in stream order, the read data and status returned, and the timeout path. The bench checks these against a behavioural flash that holds ready/busy low after confirm commands.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int LEN_W = 10,
  parameter int TW    = 4,
  parameter int BW    = 20,
  parameter int GUARD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [7:0]       req_col,
  input  logic [23:0]      req_row,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             resp_valid,
  output logic [7:0]       resp_status,
  output logic             resp_fail,
  output logic             resp_timeout,
  input  logic [TW-1:0]    cfg_wlo,
  input  logic [TW-1:0]    cfg_whi,
  input  logic [TW-1:0]    cfg_rlo,
  input  logic [TW-1:0]    cfg_rhi,
  input  logic [BW-1:0]    cfg_busy_lim,
  output logic             nf_ce_n,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic             nf_wp_n,
  output logic [7:0]       nf_dq_o,
  output logic             nf_dq_oe,
  input  logic [7:0]       nf_dq_i,
  input  logic             nf_rb
);
  localparam logic [2:0] OP_RD = 3'd0, OP_PG = 3'd1, OP_ER = 3'd2,
                         OP_ST = 3'd3, OP_ID = 3'd4, OP_RS = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_DW, S_CMD2, S_WAIT, S_CMDS, S_DR, S_RESP
  } st_t;

  st_t              st;
  logic [2:0]       op;
  logic [7:0]       col;
  logic [23:0]      row;
  logic [LEN_W-1:0] len, dcnt;
  logic [1:0]       ai;
  logic             ph, ld, tmo;
  logic [TW-1:0]    tc;
  logic [BW-1:0]    bc;
  logic [1:0]       rbs;
  logic [7:0]       dq_r, status;

  wire [TW-1:0] wlo = (cfg_wlo == '0) ? TW'(1) : cfg_wlo;
  wire [TW-1:0] whi = (cfg_whi == '0) ? TW'(1) : cfg_whi;
  wire [TW-1:0] rlo = (cfg_rlo == '0) ? TW'(1) : cfg_rlo;
  wire [TW-1:0] rhi = (cfg_rhi == '0) ? TW'(1) : cfg_rhi;

  wire wr_st    = (st == S_CMD1) || (st == S_ADDR) || (st == S_DW) ||
                  (st == S_CMD2) || (st == S_CMDS);
  wire strobing = wr_st || (st == S_DR);
  wire stb_go   = (st != S_DW) || ld;
  wire [TW-1:0] lo_lim = (st == S_DR) ? rlo : wlo;
  wire [TW-1:0] hi_lim = (st == S_DR) ? rhi : whi;
  wire lo_end   = strobing && !ph && stb_go && (tc == lo_lim - TW'(1));
  wire hi_end   = strobing && ph && (tc == hi_lim - TW'(1));
  wire st_rd    = (op == OP_PG) || (op == OP_ER) || (op == OP_ST);
  wire last_a   = (op == OP_ID) || (ai == 2'd3);
  wire last_d   = ((st == S_DR) && st_rd) || (dcnt == len - LEN_W'(1));
  wire lenz     = (len == '0);

  assign req_ready    = (st == S_IDLE);
  assign wr_ready     = (st == S_DW) && !ld;
  assign resp_valid   = (st == S_RESP);
  assign resp_status  = status;
  assign resp_fail    = status[0];
  assign resp_timeout = tmo;

  assign nf_ce_n  = (st == S_IDLE) || (st == S_RESP);
  assign nf_cle   = (st == S_CMD1) || (st == S_CMD2) || (st == S_CMDS);
  assign nf_ale   = (st == S_ADDR);
  assign nf_we_n  = !(wr_st && !ph && stb_go);
  assign nf_re_n  = !((st == S_DR) && !ph);
  assign nf_wp_n  = ((op == OP_PG) || (op == OP_ER)) && !nf_ce_n;
  assign nf_dq_oe = wr_st;

  always_comb begin
    nf_dq_o = 8'h00;
    case (st)
      S_CMD1: case (op)
        OP_RD:   nf_dq_o = 8'h00;
        OP_PG:   nf_dq_o = 8'h80;
        OP_ER:   nf_dq_o = 8'h60;
        OP_ST:   nf_dq_o = 8'h70;
        OP_ID:   nf_dq_o = 8'h90;
        default: nf_dq_o = 8'hFF;
      endcase
      S_ADDR: if (op != OP_ID) case (ai)
        2'd0:    nf_dq_o = col;
        2'd1:    nf_dq_o = row[7:0];
        2'd2:    nf_dq_o = row[15:8];
        default: nf_dq_o = row[23:16];
      endcase
      S_DW:    nf_dq_o = dq_r;
      S_CMD2:  nf_dq_o = (op == OP_PG) ? 8'h10 : 8'hD0;
      S_CMDS:  nf_dq_o = 8'h70;
      default: nf_dq_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= '0; col <= '0; row <= '0; len <= '0; dcnt <= '0;
      ai <= '0; ph <= 1'b0; ld <= 1'b0; tmo <= 1'b0; tc <= '0; bc <= '0;
      rbs <= 2'b11; dq_r <= '0; status <= '0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rbs      <= {rbs[0], nf_rb};
      rd_valid <= 1'b0;
      if (strobing) begin
        if (!ph) begin
          if (lo_end) begin ph <= 1'b1; tc <= '0; end
          else if (stb_go) tc <= tc + TW'(1);
        end else begin
          if (hi_end) begin ph <= 1'b0; tc <= '0; end
          else tc <= tc + TW'(1);
        end
      end
      if (wr_ready && wr_valid) begin dq_r <= wr_data; ld <= 1'b1; end
      if ((st == S_DR) && lo_end) begin
        if (st_rd) status <= nf_dq_i;
        else begin rd_valid <= 1'b1; rd_data <= nf_dq_i; end
      end
      case (st)
        S_IDLE: if (req_valid) begin
          op <= req_op; col <= req_col; row <= req_row; len <= req_len;
          dcnt <= '0; ai <= '0; ph <= 1'b0; tc <= '0; bc <= '0;
          ld <= 1'b0; tmo <= 1'b0; status <= '0;
          st <= (req_op > OP_RS) ? S_RESP : S_CMD1;
        end
        S_CMD1: if (hi_end) case (op)
          OP_RD, OP_PG, OP_ID: begin ai <= 2'd0; st <= S_ADDR; end
          OP_ER:               begin ai <= 2'd1; st <= S_ADDR; end
          OP_ST:               st <= S_DR;
          default:             st <= S_WAIT;
        endcase
        S_ADDR: if (hi_end) begin
          if (!last_a) ai <= ai + 2'd1;
          else case (op)
            OP_RD:   st <= S_WAIT;
            OP_PG:   st <= lenz ? S_CMD2 : S_DW;
            OP_ER:   st <= S_CMD2;
            default: st <= lenz ? S_RESP : S_DR;
          endcase
        end
        S_DW: if (hi_end) begin
          ld <= 1'b0;
          if (last_d) st <= S_CMD2;
          else dcnt <= dcnt + LEN_W'(1);
        end
        S_CMD2: if (hi_end) st <= S_WAIT;
        S_WAIT: begin
          bc <= bc + BW'(1);
          if (bc >= BW'(GUARD) && rbs[1]) begin
            if (op == OP_PG || op == OP_ER) st <= S_CMDS;
            else if (op == OP_RD && !lenz)  st <= S_DR;
            else                            st <= S_RESP;
          end else if (bc == cfg_busy_lim) begin
            tmo <= 1'b1;
            st  <= S_RESP;
          end
        end
        S_CMDS: if (hi_end) st <= S_DR;
        S_DR: if (hi_end) begin
          if (last_d) st <= S_RESP;
          else dcnt <= dcnt + LEN_W'(1);
        end
        S_RESP:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nf_ce_n,
  input logic          nf_cle,
  input logic          nf_ale,
  input logic          nf_we_n,
  input logic          nf_re_n,
  input logic          nf_wp_n,
  input logic [7:0]    nf_dq_o,
  input logic          resp_valid,
  input logic          req_ready,
  input logic [TW-1:0] cfg_wlo
);
  logic [7:0] we_run;
  wire [TW-1:0] wlo_e = (cfg_wlo == '0) ? TW'(1) : cfg_wlo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_run <= '0;
    else if (!nf_we_n) we_run <= (we_run == 8'hFF) ? we_run : we_run + 8'd1;
    else we_run <= '0;
  end

  // R2
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));
  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> ($stable(nf_cle) && $stable(nf_ale) && $stable(nf_dq_o)));
  // R2
  dq_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n && $past(!nf_we_n)) |-> $stable(nf_dq_o));
  // R3
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> (we_run >= 8'(wlo_e)));
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));
  // R11
  ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nf_ce_n |-> (nf_we_n && nf_re_n));
  // R10
  wp_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nf_wp_n |-> !nf_ce_n);
  // R11
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (!resp_valid && req_ready));
endmodule

bind nand_seq nand_seq_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
  .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_wp_n(nf_wp_n), .nf_dq_o(nf_dq_o),
  .resp_valid(resp_valid), .req_ready(req_ready), .cfg_wlo(cfg_wlo)
);

// File: tb/sim_nand_seq.sv
`timescale 1ns/1ps
module sim_nand_seq;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_ready;
  logic [2:0] req_op = 0;
  logic [7:0] req_col = 0;
  logic [23:0] req_row = 0;
  logic [9:0] req_len = 0;
  logic [7:0] wr_data = 0;
  logic wr_valid = 0, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, resp_valid, resp_fail, resp_timeout;
  logic [7:0] resp_status;
  logic [3:0] cfg_wlo = 2, cfg_whi = 2, cfg_rlo = 2, cfg_rhi = 2;
  logic [19:0] cfg_busy_lim = 20'd2000;
  logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_wp_n, nf_dq_oe, nf_rb;
  logic [7:0] nf_dq_o, nf_dq_i;

  nand_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_col(req_col), .req_row(req_row), .req_len(req_len),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .resp_valid(resp_valid),
    .resp_status(resp_status), .resp_fail(resp_fail), .resp_timeout(resp_timeout),
    .cfg_wlo(cfg_wlo), .cfg_whi(cfg_whi), .cfg_rlo(cfg_rlo), .cfg_rhi(cfg_rhi),
    .cfg_busy_lim(cfg_busy_lim), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_wp_n(nf_wp_n), .nf_dq_o(nf_dq_o),
    .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
  );

  int n_chk = 0, n_fail = 0;
  int busy_cnt = 0, ridx = 0, acnt = 0, widx = 0, rn = 0, log_n = 0, werr = 0;
  int we_lo = 0, we_hi = 0, re_lo = 0, re_hi = 0;
  bit we_up = 0, re_up = 0, pw = 1, pr = 1, stuck = 0, resp_seen = 0;
  logic [7:0] last_cmd = 8'h00, stat_val = 8'h00;
  logic [7:0] got_st;
  logic got_f, got_t;
  logic [1:0] log_t [0:63];
  logic [7:0] log_b [0:63];
  logic       log_wp[0:63];
  logic [7:0] rcap  [0:63];
  logic [7:0] wbuf  [0:63];
  logic [1:0] ex_t  [0:63];
  logic [7:0] ex_b  [0:63];
  int ex_n;

  function automatic logic [7:0] pat(input int i);
    return 8'hA5 ^ 8'(i * 13);
  endfunction
  function automatic int eff(input logic [3:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  assign nf_rb   = !(stuck || busy_cnt != 0);
  assign nf_dq_i = (last_cmd == 8'h70) ? stat_val : pat(ridx);

  always @(negedge clk) begin
    if (busy_cnt > 0) busy_cnt--;
    if (req_valid && req_ready) begin
      log_n = 0; rn = 0; widx = 0; resp_seen = 0; werr = 0; we_up = 0; re_up = 0;
    end
    if (!pw && nf_we_n) begin
      if (we_lo != eff(cfg_wlo)) werr++;
      we_up = 1; we_hi = 1;
      if (log_n < 64) begin
        log_t[log_n] = (nf_cle && nf_ale) ? 2'd0 : nf_cle ? 2'd1 : nf_ale ? 2'd2 : 2'd3;
        log_b[log_n] = nf_dq_o;
        log_wp[log_n] = nf_wp_n;
        log_n++;
      end
      if (nf_cle) begin
        last_cmd = nf_dq_o; ridx = 0; acnt = 0;
        if (nf_dq_o == 8'h10 || nf_dq_o == 8'hD0 || nf_dq_o == 8'hFF) busy_cnt = 30;
      end else if (nf_ale) begin
        acnt++;
        if (last_cmd == 8'h00 && acnt == 4) busy_cnt = 30;
      end
    end else if (pw && !nf_we_n) begin
      if (we_up && we_hi < eff(cfg_whi)) werr++;
      we_lo = 1;
    end else if (nf_we_n) we_hi++;
    else we_lo++;
    if (!pr && nf_re_n) begin
      if (re_lo != eff(cfg_rlo)) werr++;
      re_up = 1; re_hi = 1; ridx++;
    end else if (pr && !nf_re_n) begin
      if (re_up && re_hi < eff(cfg_rhi)) werr++;
      re_lo = 1;
    end else if (nf_re_n) re_hi++;
    else re_lo++;
    wr_valid = wr_ready;
    if (wr_ready) begin wr_data = wbuf[widx]; widx++; end
    if (rd_valid && rn < 64) begin rcap[rn] = rd_data; rn++; end
    if (resp_valid) begin
      resp_seen = 1; got_st = resp_status; got_f = resp_fail; got_t = resp_timeout;
    end
    pw = nf_we_n; pr = nf_re_n;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add(input logic [1:0] t, input logic [7:0] b);
    ex_t[ex_n] = t; ex_b[ex_n] = b; ex_n++;
  endtask

  task automatic run_op(input int op, input logic [7:0] c, input logic [23:0] r,
                        input int len, input bit want_tmo, input string tag);
    int bad, exr, done;
    logic [7:0] est;
    bit ewp;
    for (int i = 0; i < 64; i++) wbuf[i] = 8'($urandom);
    stat_val = 8'($urandom);
    ex_n = 0;
    case (op)
      0: begin add(1, 8'h00); add(2, c); add(2, r[7:0]); add(2, r[15:8]); add(2, r[23:16]); end
      1: begin
        add(1, 8'h80); add(2, c); add(2, r[7:0]); add(2, r[15:8]); add(2, r[23:16]);
        for (int i = 0; i < len; i++) add(3, wbuf[i]);
        add(1, 8'h10); if (!want_tmo) add(1, 8'h70);
      end
      2: begin
        add(1, 8'h60); add(2, r[7:0]); add(2, r[15:8]); add(2, r[23:16]);
        add(1, 8'hD0); if (!want_tmo) add(1, 8'h70);
      end
      3: add(1, 8'h70);
      4: begin add(1, 8'h90); add(2, 8'h00); end
      5: add(1, 8'hFF);
      default: ;
    endcase
    exr = ((op == 0 && !want_tmo) || op == 4) ? len : 0;
    est = ((op == 1 || op == 2 || op == 3) && !want_tmo) ? stat_val : 8'h00;
    ewp = (op == 1 || op == 2);
    @(posedge clk); #1;
    req_op = 3'(op); req_col = c; req_row = r; req_len = 10'(len); req_valid = 1;
    @(posedge clk); #1;
    req_valid = 0;
    done = 0;
    for (int k = 0; k < 5000 && !done; k++) begin
      @(posedge clk);
      if (resp_seen) done = 1;
    end
    chk(done == 1, "R11", {tag, " response arrives"}, done, 1);
    @(negedge clk);
    chk(req_ready && nf_ce_n, "R11", {tag, " idle after response"}, int'(req_ready), 1);
    chk(log_n == ex_n, tag, "bus cycle count", log_n, ex_n);
    bad = 0;
    for (int i = 0; i < ex_n && i < log_n; i++)
      if (log_t[i] != ex_t[i] || log_b[i] != ex_b[i]) bad++;
    chk(bad == 0, tag, "bus cycle type/byte mismatches", bad, 0);
    bad = 0;
    for (int i = 0; i < log_n; i++) if (log_t[i] == 2'd0) bad++;
    chk(bad == 0, "R2", "cycles with both markers high", bad, 0);
    chk(rn == exr, tag, "read byte count", rn, exr);
    bad = 0;
    for (int i = 0; i < exr && i < rn; i++) if (rcap[i] != pat(i)) bad++;
    chk(bad == 0, tag, "read data mismatches", bad, 0);
    chk(got_st == est && got_f == est[0], "R8", {tag, " status/fail"}, int'(got_st), int'(est));
    chk(got_t == want_tmo, "R9", {tag, " timeout flag"}, int'(got_t), int'(want_tmo));
    chk(werr == 0, "R3", {tag, " strobe width errors"}, werr, 0);
    bad = 0;
    for (int i = 0; i < log_n; i++) if (log_wp[i] != ewp) bad++;
    chk(bad == 0, "R10", {tag, " write protect level"}, bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(nf_ce_n && nf_we_n && nf_re_n && !nf_wp_n && req_ready && !resp_valid,
        "R1", "reset pin state", int'({nf_ce_n, nf_we_n, nf_re_n, nf_wp_n, req_ready, resp_valid}), 6'b111010);
    rst_n = 1;
    repeat (2) @(posedge clk);
    run_op(0, 8'h12, 24'h345678, 4, 0, "R4");
    run_op(0, 8'h01, 24'h0000AB, 0, 0, "R4");
    run_op(1, 8'h20, 24'h0A0B0C, 5, 0, "R5");
    run_op(2, 8'hEE, 24'h123456, 0, 0, "R6");
    run_op(3, 8'h00, 24'h0, 0, 0, "R7");
    run_op(4, 8'h00, 24'h0, 4, 0, "R7");
    run_op(5, 8'h00, 24'h0, 0, 0, "R7");
    run_op(6, 8'h00, 24'h0, 3, 0, "R11");
    cfg_wlo = 0; cfg_whi = 0; cfg_rlo = 0; cfg_rhi = 0;
    run_op(1, 8'h33, 24'hABCDEF, 2, 0, "R5");
    cfg_wlo = 2; cfg_whi = 2; cfg_rlo = 2; cfg_rhi = 2;
    stuck = 1; cfg_busy_lim = 20'd40;
    run_op(2, 8'h00, 24'h00F00D, 0, 1, "R9");
    run_op(0, 8'h05, 24'h010203, 3, 1, "R9");
    stuck = 0; cfg_busy_lim = 20'd2000;
    for (int k = 0; k < 40; k++) begin
      cfg_wlo = 4'($urandom_range(0, 5)); cfg_whi = 4'($urandom_range(0, 5));
      cfg_rlo = 4'($urandom_range(0, 5)); cfg_rhi = 4'($urandom_range(0, 5));
      begin
        int op = $urandom_range(0, 5);
        string tg = (op == 0) ? "R4" : (op == 1) ? "R5" : (op == 2) ? "R6" : "R7";
        run_op(op, 8'($urandom), 24'($urandom), $urandom_range(1, 6), 0, tg);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule